// File: doc/BRIEF.md
# Serial DAC Frame Receiver

This block is the digital front end of a 12-bit voltage-output converter. A host writes to it over a three-wire link: an active-low frame-sync line, a serial clock and a data line. All three lines are brought into a fast system clock through two-flop synchronisers. Edges of the serial clock and of the sync line are then detected in that clock domain. The system clock must run at least four times faster than the serial clock.

A frame opens when sync falls. While the frame is open, the block samples one data bit, most significant bit first, on each falling edge of the serial clock. On exactly the sixteenth falling edge it commits two values: the 12-bit straight-binary code into the DAC register, and a two-bit power mode into the mode register. A frame that sync closes before the sixteenth edge is thrown away and leaves no trace.

The analog section receives the held code, a power-down enable and a two-bit output-termination select. A one-cycle strobe marks every register load. Power-down modes leave the stored code in place.

Top module: `serial_dac_rx`

## Requirements
- R1: After reset, `dac_code` is 0, `term_sel` is 00, `pd_en` is 0 and `load_strobe` is 0. These values hold until the first complete frame.
- R2: A frame starts on a falling edge of `fs_n_in`. Bits are taken from `sdi_in` on falling edges of `sck_in`, MSB first. Frame bits [11:0] become `dac_code`.
- R3: Frame bits [15:14] have no effect on any output.
- R4: Frame bits [13:12] select the mode: 00 = run, 01 = power-down with a low-ohm pull-down, 10 = power-down with a high-ohm pull-down, 11 = power-down with a floating output. `term_sel` equals this field, and `pd_en` is 1 exactly when the field is not 00.
- R5: The registers load on exactly the sixteenth falling edge of `sck_in`. `load_strobe` is high for exactly one system clock cycle per committed frame, and outputs never change in a cycle where `load_strobe` is low.
- R6: If `fs_n_in` rises before the sixteenth falling edge, no output changes and no strobe occurs. The partial bits do not leak into the next frame.
- R7: Falling edges of `sck_in` after the sixteenth are ignored while `fs_n_in` stays low.
- R8: Writing a power-down mode keeps `dac_code` unchanged. Writing run mode with the same code afterwards restores the same outputs as before power-down.
- R9: `fs_n_in` may stay low after a committed frame. No new frame begins until `fs_n_in` goes high and falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fs_n_in | input | 1 | Frame sync, active low, asynchronous |
| sck_in | input | 1 | Serial clock, data taken on its falling edge |
| sdi_in | input | 1 | Serial data, MSB first |
| dac_code | output | 12 | Held converter code |
| pd_en | output | 1 | High in any power-down mode |
| term_sel | output | 2 | Output termination select (mode field) |
| load_strobe | output | 1 | One-cycle pulse on each register load |

## Verification
The hardest case to reach from the ports is a serial-clock fall that arrives while sync is low but the frame is no longer armed. This happens in two ways: edges that follow the sixteenth in the same low period, and edges that follow a commit when sync was never raised.

The driver reaches both by holding sync low across extra clock pulses that carry different data. The scoreboard expects no entry for those pulses, so any stray load appears as an unexpected strobe. Aborted frames are followed immediately by a full frame, so that leftover shift contents would show up as a wrong code.

// File: rtl/serial_dac_rx_pkg.sv
// Package: shared types and constants for the serial DAC frame receiver.
// Assumes a frame layout of two unused bits, a two-bit mode field, then the code.
package serial_dac_rx_pkg;

    // Power mode field as decoded from frame bits [13:12]
    typedef enum logic [1:0] {
        MODE_RUN       = 2'b00,
        MODE_PD_LOWR   = 2'b01,
        MODE_PD_HIGHR  = 2'b10,
        MODE_PD_FLOAT  = 2'b11
    } pwr_mode_e;

    localparam int MODE_W = 2;

endpackage

// File: rtl/link_sampler.sv
// Module: link_sampler
// Brings the three asynchronous link lines into the system clock through a
// multi-stage synchroniser and flags edges of sync and serial clock.
// Assumes the system clock is at least four times the serial clock, so no
// serial-clock edge is lost. Sync and serial clock reset to their idle-high level.
module link_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fs_n_raw,
    input  logic sck_raw,
    input  logic sdi_raw,
    output logic sck_fall,
    output logic fs_fall,
    output logic fs_rise,
    output logic sdi_bit
);

    localparam int LINES = 3;
    localparam logic [LINES-1:0] IDLE_VAL = 3'b011; // {sdi, sck, fs}

    logic [LINES-1:0] chain [STAGES];
    logic [LINES-1:0] prev_q;
    logic [LINES-1:0] cur;

    // Synchroniser stage 0 captures the raw lines
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= IDLE_VAL;
        else        chain[0] <= {sdi_raw, sck_raw, fs_n_raw};
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            // Each further stage retimes the previous one
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= IDLE_VAL;
                else        chain[s] <= chain[s-1];
            end
        end
    endgenerate

    assign cur = chain[STAGES-1];

    // Keep the last synchronised value for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= IDLE_VAL;
        else        prev_q <= cur;
    end

    // Edge flags, aligned with the data bit of the same cycle
    always_comb begin
        fs_fall  = prev_q[0] & ~cur[0];
        fs_rise  = ~prev_q[0] & cur[0];
        sck_fall = prev_q[1] & ~cur[1];
        sdi_bit  = cur[2];
    end

endmodule

// File: rtl/frame_shifter.sv
// Module: frame_shifter
// Assembles one frame from synchronised edge flags. A sync fall arms it; each
// armed serial-clock fall shifts one bit in; the FRAME_W-th fall emits the
// payload (the low PAY_W bits) with a one-cycle done flag and disarms.
// A sync rise disarms and clears any partial frame. The top frame bits are
// shifted out and never stored.
module frame_shifter #(
    parameter int FRAME_W = 16,
    parameter int PAY_W   = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck_fall,
    input  logic             fs_fall,
    input  logic             fs_rise,
    input  logic             sdi_bit,
    output logic             done,
    output logic [PAY_W-1:0] payload
);

    localparam int CNT_W = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] LAST_EDGE = CNT_W'(FRAME_W - 1);

    logic               armed_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [PAY_W-2:0]   shreg_q;
    logic [PAY_W-1:0]   next_word;

    // Word after shifting in the current bit
    always_comb next_word = {shreg_q, sdi_bit};

    // Frame sequencing: arm, shift, commit, abort
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
            shreg_q <= '0;
            done    <= 1'b0;
            payload <= '0;
        end else begin
            done <= 1'b0;
            if (fs_rise) begin
                armed_q <= 1'b0;
                cnt_q   <= '0;
                shreg_q <= '0;
            end else if (fs_fall) begin
                armed_q <= 1'b1;
                cnt_q   <= '0;
                shreg_q <= '0;
            end else if (armed_q && sck_fall) begin
                shreg_q <= next_word[PAY_W-2:0];
                if (cnt_q == LAST_EDGE) begin
                    armed_q <= 1'b0;
                    cnt_q   <= '0;
                    done    <= 1'b1;
                    payload <= next_word;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/dac_regs.sv
// Module: dac_regs
// Holds the converter code and power mode. Both load together when a complete
// frame arrives; the mode never touches the stored code. Reset gives code
// zero and run mode.
module dac_regs
    import serial_dac_rx_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [CODE_W+MODE_W-1:0] payload,
    output logic [CODE_W-1:0]        code,
    output pwr_mode_e                mode,
    output logic                     strobe
);

    // Register load on a committed frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code   <= '0;
            mode   <= MODE_RUN;
            strobe <= 1'b0;
        end else begin
            strobe <= load;
            if (load) begin
                code <= payload[CODE_W-1:0];
                mode <= pwr_mode_e'(payload[CODE_W+MODE_W-1:CODE_W]);
            end
        end
    end

endmodule

// File: rtl/serial_dac_rx.sv
// Module: serial_dac_rx (top)
// Three-wire frame receiver for a voltage-output converter: synchronises the
// link, assembles frames and drives the held code, power-down enable and
// termination select. Assumes the system clock is at least 4x the serial clock.
module serial_dac_rx
    import serial_dac_rx_pkg::*;
#(
    parameter int CODE_W      = 12,
    parameter int FRAME_W     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fs_n_in,
    input  logic              sck_in,
    input  logic              sdi_in,
    output logic [CODE_W-1:0] dac_code,
    output logic              pd_en,
    output logic [1:0]        term_sel,
    output logic              load_strobe
);

    localparam int PAY_W = CODE_W + MODE_W;

    logic             sck_fall;
    logic             fs_fall;
    logic             fs_rise;
    logic             sdi_bit;
    logic             frame_done;
    logic [PAY_W-1:0] frame_payload;
    pwr_mode_e        mode_q;

    link_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .fs_n_raw (fs_n_in),
        .sck_raw  (sck_in),
        .sdi_raw  (sdi_in),
        .sck_fall (sck_fall),
        .fs_fall  (fs_fall),
        .fs_rise  (fs_rise),
        .sdi_bit  (sdi_bit)
    );

    frame_shifter #(.FRAME_W(FRAME_W), .PAY_W(PAY_W)) u_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_fall (sck_fall),
        .fs_fall  (fs_fall),
        .fs_rise  (fs_rise),
        .sdi_bit  (sdi_bit),
        .done     (frame_done),
        .payload  (frame_payload)
    );

    dac_regs #(.CODE_W(CODE_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (frame_done),
        .payload (frame_payload),
        .code    (dac_code),
        .mode    (mode_q),
        .strobe  (load_strobe)
    );

    // Analog-side controls derived from the held mode
    always_comb begin
        term_sel = mode_q;
        pd_en    = (mode_q != MODE_RUN);
    end

endmodule

// File: rtl/serial_dac_rx_chk.sv
// Module: serial_dac_rx_chk
// Port-level checker for serial_dac_rx, attached with bind below.
module serial_dac_rx_chk #(
    parameter int CODE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fs_n_in,
    input logic [CODE_W-1:0] dac_code,
    input logic              pd_en,
    input logic [1:0]        term_sel,
    input logic              load_strobe
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (dac_code == '0 && term_sel == 2'b00 && !pd_en && !load_strobe));

    // R5
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_strobe |=> !load_strobe);

    // R5
    hold_between_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_strobe |-> ($stable(dac_code) && $stable(term_sel) && $stable(pd_en)));

    // R6
    no_load_while_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_n_in && $past(fs_n_in) && $past(fs_n_in, 2) && $past(fs_n_in, 3)
         && $past(fs_n_in, 4) && $past(fs_n_in, 5) && $past(rst_n, 5)) |-> !load_strobe);

endmodule

bind serial_dac_rx serial_dac_rx_chk #(.CODE_W(CODE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fs_n_in     (fs_n_in),
    .dac_code    (dac_code),
    .pd_en       (pd_en),
    .term_sel    (term_sel),
    .load_strobe (load_strobe)
);

// File: tb/serial_dac_rx_tb_top.sv
// Scoreboard bench: the driver pushes the expected load per full frame, the
// monitor pops and compares on every load strobe.
module serial_dac_rx_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fs_n = 1'b1;
    logic        sck = 1'b1;
    logic        sdi = 1'b0;
    logic [11:0] dac_code;
    logic        pd_en;
    logic [1:0]  term_sel;
    logic        load_strobe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [13:0] exp_q [$];
    logic [11:0] model_code = '0;
    logic [1:0]  model_mode = 2'b00;

    always #5 clk = ~clk;

    serial_dac_rx dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .fs_n_in     (fs_n),
        .sck_in      (sck),
        .sdi_in      (sdi),
        .dac_code    (dac_code),
        .pd_en       (pd_en),
        .term_sel    (term_sel),
        .load_strobe (load_strobe)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compare held outputs against the model
    task automatic check_outputs(input string req);
        check(req, {4'h0, dac_code}, {4'h0, model_code});
        check(req, {14'h0, term_sel}, {14'h0, model_mode});
        check(req, {15'h0, pd_en}, {15'h0, (model_mode != 2'b00)});
    endtask

    // Drive one frame; full frames push an expected load
    task automatic send(input logic [15:0] word, input int edges, input bit start, input bit raise);
        if (start) begin
            fs_n = 1'b0;
            #40;
        end
        if (edges >= 16 && start) begin
            exp_q.push_back(word[13:0]);
            model_code = word[11:0];
            model_mode = word[13:12];
        end
        for (int i = 0; i < edges; i++) begin
            sdi = (i < 16) ? word[15-i] : i[0];
            #40 sck = 1'b0;
            #40 sck = 1'b1;
        end
        #40;
        if (raise) fs_n = 1'b1;
        #200;
    endtask

    // Monitor: every strobe must match the oldest expected load
    always @(negedge clk) begin
        if (rst_n && load_strobe) begin
            if (exp_q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R5 unexpected load actual=%h expected=none", {term_sel, dac_code});
            end else begin
                logic [13:0] e;
                e = exp_q.pop_front();
                check("R2 code", {4'h0, dac_code}, {4'h0, e[11:0]});
                check("R4 mode", {14'h0, term_sel}, {14'h0, e[13:12]});
                check("R4 pd_en", {15'h0, pd_en}, {15'h0, (e[13:12] != 2'b00)});
            end
        end
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        #20;
        // R1 reset state
        check_outputs("R1");
        check("R1 strobe", {15'h0, load_strobe}, 16'h0);

        // R2 basic frame, run mode
        send(16'h0A5C, 16, 1, 1);
        check_outputs("R2");
        send(16'h0FFF, 16, 1, 1);
        check_outputs("R2");

        // R3 top bits ignored
        send(16'hC123, 16, 1, 1);
        check_outputs("R3");

        // R4 / R8 each power-down mode keeps code
        send(16'h1123, 16, 1, 1);
        check_outputs("R8");
        send(16'h2123, 16, 1, 1);
        check_outputs("R4");
        send(16'h3123, 16, 1, 1);
        check_outputs("R4");
        send(16'h0123, 16, 1, 1);
        check_outputs("R8");

        // R6 abort after 10 edges, then a clean frame
        send(16'hFFFF, 10, 1, 1);
        check_outputs("R6");
        send(16'h0000, 15, 1, 1);
        check_outputs("R6");
        send(16'h0801, 16, 1, 1);
        check_outputs("R6");

        // R7 extra edges after the sixteenth
        send(16'h2345, 24, 1, 1);
        check_outputs("R7");

        // R9 sync kept low, then more edges without a new fall
        send(16'h0765, 16, 1, 0);
        check_outputs("R9");
        send(16'h3FFF, 16, 0, 0);
        check_outputs("R9");
        fs_n = 1'b1;
        #200;
        send(16'h1ABC, 16, 1, 1);
        check_outputs("R9");

        #200;
        check("R5 queue drained", 16'(exp_q.size()), 16'h0);
        done = 1'b1;
        finish_run();
    end

endmodule